// File: doc/BRIEF.md
# Packet Byte Counter and Acknowledge Sequencer

This block sits beside a byte-level I2C/SMBus shift engine. It follows the bytes of one packet and, for each byte being received, decides whether the engine should answer with ACK or NACK. A hardware down-counter holds the number of data bytes still expected. It is loaded from a packet-size input while the bus is idle, and it skips address bytes. An end-of-packet status pulse marks the point where the packet is complete, either after the last data byte or after a trailing PEC byte.

The acknowledge choice comes from a two-bit mode. Software can supply the bit directly. The block can also acknowledge everything, NACK only the final byte, or answer the final PEC byte from the CRC check result (NACK when acting as host). When extended packets are enabled, reaching the end of a packet reloads the counter so that reception continues. A host-side control can make the block treat a NACK from the far end as an ACK.

The engine reports each finished byte with a one-cycle strobe. Together with the strobe it gives a flag that says whether that byte was an address byte or a data byte. All state changes happen on the clock edge where the strobe is sampled.

Top module: `pkt_ack_seq`

## Requirements
- R1: After synchronous reset, bytes_left is 1, eop_pulse is 0 and no PEC byte is pending.
- R2: While bus_idle is 1, bytes_left takes pkt_size one cycle later, and pec_en is captured in the same cycle as the PEC-pending flag. While bus_idle is 0 and byte_strobe is 0, bytes_left does not change. A change of pkt_size in the middle of a packet does not alter bytes_left.
- R3: A byte_strobe with data_byte=1 (data byte) decrements bytes_left by one. A byte_strobe with data_byte=0 (address byte) leaves bytes_left unchanged. bytes_left saturates at 0. A data byte that arrives while bytes_left is 0 and a PEC byte is pending is the PEC byte, and it clears the pending flag.
- R4: With eop_ctl=01, eop_pulse is high for exactly the one cycle after the strobe of the data byte that takes bytes_left from 1 to 0. When bytes_left is already 0, eop_pulse instead follows the first address byte, which gives a quick command. It fires once per packet.
- R5: With eop_ctl=10 and a PEC byte pending, eop_pulse follows the PEC byte and not the last data byte. With eop_ctl=10 and no PEC byte pending, the behaviour is that of eop_ctl=01.
- R6: With eop_ctl=00 or 11, eop_pulse is never raised.
- R7: With ext_pkt_en=1, the byte that raises eop_pulse also reloads bytes_left from the current pkt_size and re-captures pec_en, so a further packet end can be reported. With ext_pkt_en=0, bytes_left stays at 0 after the packet.
- R8: ack_bit is 1 for ACK and 0 for NACK. With ack_ctl=00, ack_bit equals sw_ack_bit.
- R9: With ack_ctl=01, ack_bit is 1 for address bytes and for every packet data byte, including the last one.
- R10: With ack_ctl=10, ack_bit is 0 for the final byte and 1 for all other bytes. The final byte is the PEC byte when a PEC byte is pending; otherwise it is the data byte seen while bytes_left is 1.
- R11: With ack_ctl=11, ack_bit for the PEC byte equals crc_is_zero when host_mode=0 and is 0 when host_mode=1. All other packet bytes get ack_bit=1.
- R12: With ack_ctl other than 00, a data byte beyond the packet (bytes_left 0 and no PEC pending) gets ack_bit = sw_ack_bit.
- R13: far_ack equals the inverse of far_nack. The exception is host_mode=1 with nack_as_ack=1, where far_ack is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_idle | input | 1 | Bus is idle; load packet size and PEC enable |
| host_mode | input | 1 | 1 when this end drives the bus as host |
| byte_strobe | input | 1 | One-cycle pulse when a byte has finished |
| data_byte | input | 1 | Current byte is data (1) or address (0) |
| pkt_size | input | CW | Number of data bytes in a packet |
| pec_en | input | 1 | Packet carries a trailing PEC byte |
| ack_ctl | input | 2 | Acknowledge mode |
| eop_ctl | input | 2 | End-of-packet mode |
| ext_pkt_en | input | 1 | Reload on end of packet and keep receiving |
| sw_ack_bit | input | 1 | Software acknowledge bit (1 = ACK) |
| crc_is_zero | input | 1 | Running CRC residue is zero |
| far_nack | input | 1 | Far end answered NACK |
| nack_as_ack | input | 1 | Host treats a far-end NACK as ACK |
| ack_bit | output | 1 | Acknowledge to send for the current byte (1 = ACK) |
| far_ack | output | 1 | Effective far-end acknowledge |
| eop_pulse | output | 1 | One-cycle end-of-packet status |
| bytes_left | output | CW | Data bytes still expected |

## Verification
The bench aims at the quick command of size zero. A design that only counted data bytes would never raise the end-of-packet pulse there, and one that did not guard it would raise it again on a repeated address. It checks that a trailing PEC byte moves both the end-of-packet pulse and the final NACK one byte later. An off-by-one design would NACK or flag the last data byte instead. It also covers bytes beyond the packet, where a design missing the fallback would keep acknowledging, and a packet-size change in the middle of a packet, which an unlatched design would pick up at once and so corrupt the count. The extended-packet reload and the full 16-bit size are covered as well, along with the host NACK answer on the PEC byte, which a design that ignored the role would replace with the CRC result.

// File: rtl/pkt_ack_seq.sv
module pkt_ack_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_idle,
  input  logic          host_mode,
  input  logic          byte_strobe,
  input  logic          data_byte,
  input  logic [CW-1:0] pkt_size,
  input  logic          pec_en,
  input  logic [1:0]    ack_ctl,
  input  logic [1:0]    eop_ctl,
  input  logic          ext_pkt_en,
  input  logic          sw_ack_bit,
  input  logic          crc_is_zero,
  input  logic          far_nack,
  input  logic          nack_as_ack,
  output logic          ack_bit,
  output logic          far_ack,
  output logic          eop_pulse,
  output logic [CW-1:0] bytes_left
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic          pec_left;
  logic          fired;

  wire cnt_zero = (cnt == '0);
  wire cnt_one  = (cnt == ONE);
  wire eop_on   = (eop_ctl == 2'b01) || (eop_ctl == 2'b10);
  wire pec_end  = (eop_ctl == 2'b10) && pec_left;

  wire hit = eop_on && (pec_end ? (data_byte && cnt_zero)
                                : (data_byte ? cnt_one : (cnt_zero && !fired)));

  wire pec_byte = data_byte && cnt_zero && pec_left;
  wire beyond   = data_byte && cnt_zero && !pec_left;
  wire last_one = pec_left ? pec_byte : (data_byte && cnt_one);

  always_comb begin
    unique case (ack_ctl)
      2'b00:   ack_bit = sw_ack_bit;
      2'b01:   ack_bit = beyond ? sw_ack_bit : 1'b1;
      2'b10:   ack_bit = beyond ? sw_ack_bit : !last_one;
      default: ack_bit = beyond ? sw_ack_bit
                       : (pec_byte ? (!host_mode && crc_is_zero) : 1'b1);
    endcase
  end

  assign far_ack    = !far_nack || (host_mode && nack_as_ack);
  assign bytes_left = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= ONE;
      pec_left  <= 1'b0;
      fired     <= 1'b0;
      eop_pulse <= 1'b0;
    end else begin
      eop_pulse <= byte_strobe && !bus_idle && hit;
      if (bus_idle) begin
        cnt      <= pkt_size;
        pec_left <= pec_en;
        fired    <= 1'b0;
      end else if (byte_strobe) begin
        if (hit && ext_pkt_en) begin
          cnt      <= pkt_size;
          pec_left <= pec_en;
          fired    <= 1'b0;
        end else begin
          if (data_byte) begin
            if (!cnt_zero) cnt <= cnt - ONE;
            else           pec_left <= 1'b0;
          end
          if (hit) fired <= 1'b1;
        end
      end
    end
  end

endmodule

module pkt_ack_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_idle,
  input logic          host_mode,
  input logic          byte_strobe,
  input logic          data_byte,
  input logic [CW-1:0] pkt_size,
  input logic [1:0]    ack_ctl,
  input logic [1:0]    eop_ctl,
  input logic          sw_ack_bit,
  input logic          nack_as_ack,
  input logic          ack_bit,
  input logic          far_ack,
  input logic          eop_pulse,
  input logic [CW-1:0] bytes_left
);

  AST_LOAD_SIZE: assert property (@(posedge clk) disable iff (rst)
    bus_idle |=> bytes_left == $past(pkt_size)); // R2

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle && !byte_strobe) |=> $stable(bytes_left)); // R2

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle && byte_strobe && data_byte && bytes_left > CW'(1))
      |=> bytes_left == $past(bytes_left) - CW'(1)); // R3

  AST_ADDR_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle && byte_strobe && !data_byte && bytes_left != '0)
      |=> $stable(bytes_left)); // R3

  AST_EOP_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    !byte_strobe |=> !eop_pulse); // R4

  AST_EOP_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (eop_ctl[1] == eop_ctl[0]) |=> !eop_pulse); // R6

  AST_SW_ACK_MODE: assert property (@(posedge clk) disable iff (rst)
    (ack_ctl == 2'b00) |-> ack_bit == sw_ack_bit); // R8

  AST_NACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (host_mode && nack_as_ack) |-> far_ack); // R13

endmodule

bind pkt_ack_seq pkt_ack_seq_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .bus_idle(bus_idle), .host_mode(host_mode),
  .byte_strobe(byte_strobe), .data_byte(data_byte), .pkt_size(pkt_size),
  .ack_ctl(ack_ctl), .eop_ctl(eop_ctl), .sw_ack_bit(sw_ack_bit),
  .nack_as_ack(nack_as_ack), .ack_bit(ack_bit), .far_ack(far_ack),
  .eop_pulse(eop_pulse), .bytes_left(bytes_left)
);

// File: tb/pkt_ack_seq_tb.sv
module pkt_ack_seq_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, bus_idle, host_mode, byte_strobe, data_byte, pec_en;
  logic [15:0] pkt_size;
  logic [1:0]  ack_ctl, eop_ctl;
  logic        ext_pkt_en, sw_ack_bit, crc_is_zero, far_nack, nack_as_ack;
  logic        ack_bit, far_ack, eop_pulse;
  logic [15:0] bytes_left;

  pkt_ack_seq #(.CW(16)) dut_i (
    .clk(clk), .rst(rst), .bus_idle(bus_idle), .host_mode(host_mode),
    .byte_strobe(byte_strobe), .data_byte(data_byte), .pkt_size(pkt_size),
    .pec_en(pec_en), .ack_ctl(ack_ctl), .eop_ctl(eop_ctl),
    .ext_pkt_en(ext_pkt_en), .sw_ack_bit(sw_ack_bit), .crc_is_zero(crc_is_zero),
    .far_nack(far_nack), .nack_as_ack(nack_as_ack), .ack_bit(ack_bit),
    .far_ack(far_ack), .eop_pulse(eop_pulse), .bytes_left(bytes_left)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  logic [15:0] m_cnt;
  bit          m_pec, m_fired;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit m_hit(bit d);
    bit pe;
    if (eop_ctl == 2'b00 || eop_ctl == 2'b11) return 1'b0;
    pe = (eop_ctl == 2'b10) && m_pec;
    if (pe) return d && m_cnt == 0;
    return d ? (m_cnt == 1) : (m_cnt == 0 && !m_fired);
  endfunction

  function automatic bit m_ack(bit d);
    bit pecb, bey, fin;
    pecb = d && m_cnt == 0 && m_pec;
    bey  = d && m_cnt == 0 && !m_pec;
    fin  = m_pec ? pecb : (d && m_cnt == 1);
    case (ack_ctl)
      2'b00:   return sw_ack_bit;
      2'b01:   return bey ? sw_ack_bit : 1'b1;
      2'b10:   return bey ? sw_ack_bit : !fin;
      default: return bey ? sw_ack_bit : (pecb ? (!host_mode && crc_is_zero) : 1'b1);
    endcase
  endfunction

  function automatic string ack_tag(bit d);
    if (ack_ctl == 2'b00) return "R8 sw ack";
    if (d && m_cnt == 0 && !m_pec) return "R12 beyond packet";
    case (ack_ctl)
      2'b01:   return "R9 ack all";
      2'b10:   return "R10 nack final";
      default: return "R11 crc ack";
    endcase
  endfunction

  task automatic start_pkt(input int len, input bit pec);
    bus_idle = 1'b1;
    pkt_size = 16'(len);
    pec_en   = pec;
    @(posedge clk);
    @(negedge clk);
    bus_idle = 1'b0;
    m_cnt = 16'(len); m_pec = pec; m_fired = 1'b0;
    check("R2 load size", bytes_left, 32'(len));
  endtask

  task automatic do_byte(input bit d);
    bit h;
    string et, ct;
    data_byte   = d;
    sw_ack_bit  = 1'($urandom);
    crc_is_zero = 1'($urandom);
    far_nack    = 1'($urandom);
    nack_as_ack = 1'($urandom);
    #1;
    check(ack_tag(d), ack_bit, m_ack(d));
    check("R13 far ack", far_ack, !far_nack || (host_mode && nack_as_ack));
    h = m_hit(d);
    if (eop_ctl == 2'b00 || eop_ctl == 2'b11) et = "R6 eop off";
    else if (h && ext_pkt_en)                et = "R7 ext eop";
    else if (eop_ctl == 2'b01)               et = "R4 eop data";
    else                                     et = "R5 eop pec";
    ct = (h && ext_pkt_en) ? "R7 reload" : "R3 count";
    byte_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    byte_strobe = 1'b0;
    if (h && ext_pkt_en) begin
      m_cnt = pkt_size; m_pec = pec_en; m_fired = 1'b0;
    end else begin
      if (d) begin
        if (m_cnt != 0) m_cnt = m_cnt - 16'd1;
        else            m_pec = 1'b0;
      end
      if (h) m_fired = 1'b1;
    end
    check(et, eop_pulse, h);
    check(ct, bytes_left, m_cnt);
  endtask

  task automatic set_modes(input logic [1:0] a, input logic [1:0] e,
                           input bit host, input bit ext);
    ack_ctl = a; eop_ctl = e; host_mode = host; ext_pkt_en = ext;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    rst = 1'b1; bus_idle = 1'b0; host_mode = 1'b0; byte_strobe = 1'b0;
    data_byte = 1'b0; pec_en = 1'b0; pkt_size = 16'd7; ack_ctl = 2'b00;
    eop_ctl = 2'b00; ext_pkt_en = 1'b0; sw_ack_bit = 1'b0; crc_is_zero = 1'b0;
    far_nack = 1'b0; nack_as_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset count", bytes_left, 32'd1);
    check("R1 reset eop", eop_pulse, 32'd0);
    m_cnt = 16'd1; m_pec = 1'b0; m_fired = 1'b0;

    // R10 from reset state: single data byte is the final one
    set_modes(2'b10, 2'b01, 1'b0, 1'b0);
    do_byte(1'b1);

    // R4 quick command, then repeated address must not fire again
    set_modes(2'b01, 2'b01, 1'b0, 1'b0);
    start_pkt(0, 1'b0);
    do_byte(1'b0);
    do_byte(1'b0);
    do_byte(1'b1);

    // R5 / R11 client PEC byte
    set_modes(2'b11, 2'b10, 1'b0, 1'b0);
    start_pkt(2, 1'b1);
    do_byte(1'b0); do_byte(1'b1); do_byte(1'b1); do_byte(1'b1); do_byte(1'b1);

    // R11 host NACKs the PEC byte
    set_modes(2'b11, 2'b10, 1'b1, 1'b0);
    start_pkt(1, 1'b1);
    do_byte(1'b0); do_byte(1'b1); do_byte(1'b1);

    // R3 full-width size
    set_modes(2'b01, 2'b01, 1'b0, 1'b0);
    start_pkt(65535, 1'b0);
    do_byte(1'b1); do_byte(1'b0); do_byte(1'b1);

    // R2 size change in mid packet is not picked up
    start_pkt(3, 1'b0);
    do_byte(1'b0);
    pkt_size = 16'd9;
    do_byte(1'b1); do_byte(1'b1); do_byte(1'b1); do_byte(1'b1);

    // R7 extended packets
    set_modes(2'b01, 2'b01, 1'b0, 1'b1);
    start_pkt(2, 1'b0);
    do_byte(1'b0);
    for (int i = 0; i < 5; i++) do_byte(1'b1);

    // random mix
    for (int p = 0; p < 400; p++) begin
      int len, n;
      bit pec;
      set_modes(2'($urandom), 2'($urandom), 1'($urandom), ($urandom % 4) == 0);
      len = ($urandom % 10 == 0) ? int'($urandom_range(5, 40)) : int'($urandom_range(0, 4));
      pec = 1'($urandom);
      start_pkt(len, pec);
      do_byte(1'b0);
      n = len + int'(pec) + int'($urandom_range(0, 2));
      for (int b = 0; b < n; b++) begin
        if ($urandom % 10 == 0) pkt_size = 16'($urandom_range(0, 6));
        do_byte(($urandom % 8) != 0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule